// File: doc/BRIEF.md
# Two-Wire Debug Port Frame Engine

This block is the host end of a two-wire serial debug link: one clock line that the host always drives, and one data line whose direction changes within a frame. A controller issues one request at a time on a valid/ready command port. The request is either a reset or one of four single-byte frames: write the address register, read it, write the data register, or read it. The engine produces every clock strobe, drives or releases the data line bit by bit, and for reads assembles the received byte. It then raises a one-cycle completion pulse, which carries the byte and an error flag.

All timing comes from the system clock through cycle-count parameters. These cover the short low and high phases of a strobe, the long low time that the target reads as a reset, the recovery after that reset, the number of polls allowed while the target is busy, and the pause between polls. A normal strobe is never allowed to stay low long enough to be mistaken for a reset. Data-register frames include a target-paced wait phase. In it the host keeps strobing with the line released until the target pulls the line high. If the target never does, the frame is abandoned and flagged. The data input passes through a parameterised synchroniser. Its depth must be smaller than the combined low and high phase counts.

Top module: `dbgwire_frame_engine`

## Requirements
- R1: After reset the clock line is high and its output enable low, and the data line is released. The clock output enable follows `access_en` one cycle later, so the clock is already high when the enable rises. `req_ready` is high only while the engine is idle and the clock output is enabled.
- R2: Every frame strobe holds the clock low for exactly LOW_CYC cycles, and the clock then stays high for at least HIGH_CYC cycles before the next strobe.
- R3: Every frame begins with one strobe with the data line released. Next come two driven instruction bits, `req_op[0]` then `req_op[1]`, coded 00 data read, 01 data write, 10 address read and 11 address write.
- R4: Data-register frames follow the instruction with two driven zero bits, which select a one-byte length. Address-register frames have no such field.
- R5: On writes, the 8 bits of `req_data` are driven least significant bit first, one per strobe, and the data line never changes while the clock is low.
- R6: On reads, the line is released for all 8 byte strobes. The line is sampled after each strobe and shifted in from the top, so the first bit received becomes `rdata[0]`. An address read releases the line right after the instruction bits.
- R7: A data write sends its byte and then waits for the target. A data read waits first and then receives its byte.
- R8: In the wait phase the line is released and the engine strobes until it samples the line high, using at most WAIT_LIMIT strobes. Between two polls the clock stays high for at least HIGH_CYC+WAIT_GAP_CYC cycles.
- R9: If WAIT_LIMIT polls all sample low, the frame ends without a closing strobe, and `done` is raised with `err` high and `rdata` zero.
- R10: A successful frame ends with one strobe with the line released, then a one-cycle `done` with `err` low. For writes, `rdata` is zero.
- R11: A reset request produces a single clock low of exactly RST_LOW_CYC cycles. The clock then stays high for at least RST_HIGH_CYC cycles before `done` with `err` low.
- R12: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` drops in the next cycle and stays low until `done`, and a request offered while not ready starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| access_en | input | 1 | Enables driving of the clock line |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_reset | input | 1 | Request is a target reset instead of a frame |
| req_op | input | 2 | Frame type (instruction code) |
| req_data | input | 8 | Byte to send for write frames |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Wait phase expired; valid with `done` |
| rdata | output | 8 | Received byte; valid with `done` |
| ck_out | output | 1 | Clock line level |
| ck_oe | output | 1 | Clock line output enable |
| dat_out | output | 1 | Data line level when driven |
| dat_oe | output | 1 | Data line output enable |
| dat_in | input | 1 | Data line as seen at the pad |

## Verification
Address writes and address reads are swept over all 256 byte values. This separates bit order, bit inversion and off-by-one shift faults, in both the driven and the sampled direction. Data writes and data reads are run with the target holding the line low for zero up to beyond WAIT_LIMIT polls. That shows where the wait phase sits relative to the byte, that the poll count is exact at the limit, that the pause between polls is present, and that an expired wait drops the closing strobe and raises the error. A reset request and a request offered before access is enabled check the long low pulse and the handshake gating.

// File: rtl/dbgwire_pkg.sv
// Shared types for the two-wire debug port frame engine.
package dbgwire_pkg;

    // Instruction codes; the two bits are sent on the wire bit 0 first.
    typedef enum logic [1:0] {
        OP_DREAD  = 2'b00,
        OP_DWRITE = 2'b01,
        OP_AREAD  = 2'b10,
        OP_AWRITE = 2'b11
    } dw_op_e;

    // Frame sequencer states.
    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RST,
        SQ_START,
        SQ_INS,
        SQ_LEN,
        SQ_TXB,
        SQ_RXB,
        SQ_WAIT,
        SQ_GAP,
        SQ_STOP
    } dw_state_e;

    // Strobe generator phases.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } dw_phase_e;

endpackage

// File: rtl/dbgwire_strobe_gen.sv
// Clock strobe generator.
// Produces one high-low-high pulse per go request. A short pulse lasts
// LOW_CYC low then HIGH_CYC high; a long pulse (reset) lasts LONG_LOW_CYC
// low then LONG_HIGH_CYC high. fin is high in the last high cycle.
// Assumes go arrives only while no pulse is in progress; all counts >= 1.
module dbgwire_strobe_gen
    import dbgwire_pkg::*;
#(
    parameter int LOW_CYC       = 125,
    parameter int HIGH_CYC      = 125,
    parameter int LONG_LOW_CYC  = 3125,
    parameter int LONG_HIGH_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic long_sel,
    output logic ck,
    output logic fin
);

    localparam int MAX_A = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int MAX_B = (LONG_LOW_CYC > LONG_HIGH_CYC) ? LONG_LOW_CYC : LONG_HIGH_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_C + 1);

    localparam logic [CW-1:0] LD_LOW   = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] LD_HIGH  = CW'(HIGH_CYC - 1);
    localparam logic [CW-1:0] LD_LLOW  = CW'(LONG_LOW_CYC - 1);
    localparam logic [CW-1:0] LD_LHIGH = CW'(LONG_HIGH_CYC - 1);

    dw_phase_e     phase;
    logic [CW-1:0] cnt;
    logic          long_q;
    logic          ck_q;

    // Phase sequencing and per-phase cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            long_q <= 1'b0;
            ck_q   <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase  <= PH_LOW;
                        ck_q   <= 1'b0;
                        long_q <= long_sel;
                        cnt    <= long_sel ? LD_LLOW : LD_LOW;
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        phase <= PH_HIGH;
                        ck_q  <= 1'b1;
                        cnt   <= long_q ? LD_LHIGH : LD_HIGH;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Completion flag for the sequencer.
    always_comb begin
        fin = (phase == PH_HIGH) && (cnt == '0);
    end

    assign ck = ck_q;

endmodule

// File: rtl/dbgwire_frame_seq.sv
// Frame sequencer.
// Walks a request through START, instruction, length, byte, wait and STOP
// steps, asking the strobe generator for one strobe per step and updating
// the data line only while the clock is high. Samples din after each strobe.
// Assumes din is already synchronised and settles within one strobe.
module dbgwire_frame_seq
    import dbgwire_pkg::*;
#(
    parameter int WAIT_LIMIT   = 20,
    parameter int WAIT_GAP_CYC = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_rst,
    input  dw_op_e     start_op,
    input  logic [7:0] start_data,
    output logic       idle,
    output logic       sg_go,
    output logic       sg_long,
    input  logic       sg_fin,
    input  logic       din,
    output logic       dat_out,
    output logic       dat_oe,
    output logic       done,
    output logic       err,
    output logic [7:0] rdata
);

    localparam int WCW = $clog2(WAIT_LIMIT + 1);
    localparam int GCW = $clog2(WAIT_GAP_CYC + 1);
    localparam logic [WCW-1:0] W_LAST = WCW'(WAIT_LIMIT - 1);
    localparam logic [GCW-1:0] G_LOAD = GCW'(WAIT_GAP_CYC - 1);

    dw_state_e      state;
    dw_op_e         op_q;
    logic [7:0]     shreg;
    logic [2:0]     bcnt;
    logic [WCW-1:0] wcnt;
    logic [GCW-1:0] gcnt;
    logic           launch;
    logic           long_q;
    logic           dout_q;
    logic           doe_q;
    logic           done_q;
    logic           err_q;
    logic [7:0]     rdata_q;
    logic           is_read;

    // Read frames return the shifted byte.
    always_comb begin
        is_read = (op_q == OP_DREAD) || (op_q == OP_AREAD);
    end

    // Frame step sequencing, data line control and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            op_q    <= OP_DREAD;
            shreg   <= '0;
            bcnt    <= '0;
            wcnt    <= '0;
            gcnt    <= '0;
            launch  <= 1'b0;
            long_q  <= 1'b0;
            dout_q  <= 1'b0;
            doe_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            launch <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        launch <= 1'b1;
                        doe_q  <= 1'b0;
                        if (start_rst) begin
                            state  <= SQ_RST;
                            long_q <= 1'b1;
                        end else begin
                            state  <= SQ_START;
                            long_q <= 1'b0;
                            op_q   <= start_op;
                            shreg  <= start_data;
                        end
                    end
                end
                SQ_RST: begin
                    if (sg_fin) begin
                        state   <= SQ_IDLE;
                        long_q  <= 1'b0;
                        done_q  <= 1'b1;
                        rdata_q <= '0;
                    end
                end
                SQ_START: begin
                    if (sg_fin) begin
                        state  <= SQ_INS;
                        bcnt   <= '0;
                        doe_q  <= 1'b1;
                        dout_q <= op_q[0];
                        launch <= 1'b1;
                    end
                end
                SQ_INS: begin
                    if (sg_fin) begin
                        launch <= 1'b1;
                        bcnt   <= '0;
                        if (bcnt == 3'd0) begin
                            bcnt   <= 3'd1;
                            dout_q <= op_q[1];
                        end else if (!op_q[1]) begin
                            state  <= SQ_LEN;
                            dout_q <= 1'b0;
                        end else if (op_q == OP_AWRITE) begin
                            state  <= SQ_TXB;
                            dout_q <= shreg[0];
                        end else begin
                            state <= SQ_RXB;
                            doe_q <= 1'b0;
                        end
                    end
                end
                SQ_LEN: begin
                    if (sg_fin) begin
                        launch <= 1'b1;
                        bcnt   <= '0;
                        if (bcnt == 3'd0) begin
                            bcnt <= 3'd1;
                        end else if (op_q == OP_DWRITE) begin
                            state  <= SQ_TXB;
                            dout_q <= shreg[0];
                        end else begin
                            state <= SQ_WAIT;
                            doe_q <= 1'b0;
                            wcnt  <= '0;
                        end
                    end
                end
                SQ_TXB: begin
                    if (sg_fin) begin
                        launch <= 1'b1;
                        if (bcnt == 3'd7) begin
                            doe_q <= 1'b0;
                            wcnt  <= '0;
                            state <= (op_q == OP_AWRITE) ? SQ_STOP : SQ_WAIT;
                        end else begin
                            bcnt   <= bcnt + 3'd1;
                            shreg  <= {1'b0, shreg[7:1]};
                            dout_q <= shreg[1];
                        end
                    end
                end
                SQ_RXB: begin
                    if (sg_fin) begin
                        launch <= 1'b1;
                        shreg  <= {din, shreg[7:1]};
                        if (bcnt == 3'd7) begin
                            state <= SQ_STOP;
                        end else begin
                            bcnt <= bcnt + 3'd1;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (sg_fin) begin
                        if (din) begin
                            launch <= 1'b1;
                            bcnt   <= '0;
                            state  <= (op_q == OP_DWRITE) ? SQ_STOP : SQ_RXB;
                        end else if (wcnt == W_LAST) begin
                            state   <= SQ_IDLE;
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            rdata_q <= '0;
                        end else begin
                            wcnt  <= wcnt + 1'b1;
                            gcnt  <= G_LOAD;
                            state <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    if (gcnt == '0) begin
                        state  <= SQ_WAIT;
                        launch <= 1'b1;
                    end else begin
                        gcnt <= gcnt - 1'b1;
                    end
                end
                SQ_STOP: begin
                    if (sg_fin) begin
                        state   <= SQ_IDLE;
                        done_q  <= 1'b1;
                        rdata_q <= is_read ? shreg : 8'h00;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign idle    = (state == SQ_IDLE);
    assign sg_go   = launch;
    assign sg_long = long_q;
    assign dat_out = dout_q;
    assign dat_oe  = doe_q;
    assign done    = done_q;
    assign err     = err_q;
    assign rdata   = rdata_q;

endmodule

// File: rtl/dbgwire_frame_engine.sv
// Two-wire debug port frame engine, top level.
// Gates the command port on idle and clock enable, synchronises the data
// input, and joins the frame sequencer to the strobe generator.
// Assumes SYNC_STAGES < LOW_CYC + HIGH_CYC so a bit settles within a strobe.
module dbgwire_frame_engine
    import dbgwire_pkg::*;
#(
    parameter int LOW_CYC      = 125,
    parameter int HIGH_CYC     = 125,
    parameter int RST_LOW_CYC  = 3125,
    parameter int RST_HIGH_CYC = 125,
    parameter int WAIT_LIMIT   = 20,
    parameter int WAIT_GAP_CYC = 125,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       access_en,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_reset,
    input  logic [1:0] req_op,
    input  logic [7:0] req_data,
    output logic       done,
    output logic       err,
    output logic [7:0] rdata,
    output logic       ck_out,
    output logic       ck_oe,
    output logic       dat_out,
    output logic       dat_oe,
    input  logic       dat_in
);

    logic                   ck_oe_q;
    logic                   seq_idle;
    logic                   sg_go;
    logic                   sg_long;
    logic                   sg_fin;
    logic                   accept;
    logic [SYNC_STAGES-1:0] sync_q;

    // Clock enable lags access_en by a cycle; the clock idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_oe_q <= 1'b0;
        end else begin
            ck_oe_q <= access_en;
        end
    end

    // Data input synchroniser chain.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g] <= dat_in;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    // Request gating.
    always_comb begin
        req_ready = seq_idle && ck_oe_q;
        accept    = req_valid && req_ready;
    end

    dbgwire_frame_seq #(
        .WAIT_LIMIT   (WAIT_LIMIT),
        .WAIT_GAP_CYC (WAIT_GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_rst  (req_reset),
        .start_op   (dw_op_e'(req_op)),
        .start_data (req_data),
        .idle       (seq_idle),
        .sg_go      (sg_go),
        .sg_long    (sg_long),
        .sg_fin     (sg_fin),
        .din        (sync_q[SYNC_STAGES-1]),
        .dat_out    (dat_out),
        .dat_oe     (dat_oe),
        .done       (done),
        .err        (err),
        .rdata      (rdata)
    );

    dbgwire_strobe_gen #(
        .LOW_CYC       (LOW_CYC),
        .HIGH_CYC      (HIGH_CYC),
        .LONG_LOW_CYC  (RST_LOW_CYC),
        .LONG_HIGH_CYC (RST_HIGH_CYC)
    ) u_sg (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (sg_go),
        .long_sel (sg_long),
        .ck       (ck_out),
        .fin      (sg_fin)
    );

    assign ck_oe = ck_oe_q;

endmodule

// File: rtl/dbgwire_frame_checker.sv
// Protocol checker for the frame engine, attached by bind.
// Watches the port level: clock enable ordering, short low pulses outside
// a reset, data line stability while low, and the command handshake.
module dbgwire_frame_checker #(
    parameter int LOW_CYC = 125
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic req_reset,
    input logic done,
    input logic err,
    input logic ck_out,
    input logic ck_oe,
    input logic dat_out,
    input logic dat_oe
);

    logic [31:0] lowrun;
    logic        rst_mode;

    // Counts consecutive earlier cycles with the clock low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lowrun <= '0;
        end else begin
            lowrun <= ck_out ? 32'd0 : lowrun + 32'd1;
        end
    end

    // Marks that an accepted reset request is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_mode <= 1'b0;
        end else if (req_valid && req_ready && req_reset) begin
            rst_mode <= 1'b1;
        end else if (done) begin
            rst_mode <= 1'b0;
        end
    end

    // R1: clock already high when its enable rises.
    assert_ck_high_before_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ck_oe) |-> $past(ck_out));

    // R1: data line released whenever a request could be taken.
    assert_released_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !dat_oe);

    // R2: a frame strobe never stays low longer than LOW_CYC cycles.
    assert_short_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_out && !rst_mode) |-> (lowrun < LOW_CYC));

    // R5: data line level and direction hold while the clock is low.
    assert_data_stable_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_out |-> ($stable(dat_out) && $stable(dat_oe)));

    // R9: the error flag only appears with completion.
    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10: completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: ready drops after a request is taken.
    assert_ready_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind dbgwire_frame_engine dbgwire_frame_checker #(
    .LOW_CYC (LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_reset (req_reset),
    .done      (done),
    .err       (err),
    .ck_out    (ck_out),
    .ck_oe     (ck_oe),
    .dat_out   (dat_out),
    .dat_oe    (dat_oe)
);

// File: tb/sim_dbgwire_frame_engine.sv
`timescale 1ns/1ps
module sim_dbgwire_frame_engine;

    localparam int LOW   = 2;
    localparam int HIGH  = 2;
    localparam int RLOW  = 10;
    localparam int RHIGH = 3;
    localparam int WLIM  = 4;
    localparam int WGAP  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       access_en = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_reset = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [7:0] req_data = 8'h00;
    logic       done;
    logic       err;
    logic [7:0] rdata;
    logic       ck_out;
    logic       ck_oe;
    logic       dat_out;
    logic       dat_oe;
    logic       dat_in = 1'b0;

    always #4 clk = ~clk;

    dbgwire_frame_engine #(
        .LOW_CYC      (LOW),
        .HIGH_CYC     (HIGH),
        .RST_LOW_CYC  (RLOW),
        .RST_HIGH_CYC (RHIGH),
        .WAIT_LIMIT   (WLIM),
        .WAIT_GAP_CYC (WGAP),
        .SYNC_STAGES  (2)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .access_en (access_en),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_reset (req_reset),
        .req_op    (req_op),
        .req_data  (req_data),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .ck_out    (ck_out),
        .ck_oe     (ck_oe),
        .dat_out   (dat_out),
        .dat_oe    (dat_oe),
        .dat_in    (dat_in)
    );

    int ncmp = 0;
    int nfail = 0;
    int cyc = 0;

    // Target model state and line monitor results.
    logic [1:0]  cur_op = 2'b00;
    int          cur_wz = 0;
    logic [7:0]  cur_rb = 8'h00;
    int          nstb = 0;
    int          lowrun = 0;
    int          hirun = 0;
    int          minlow = 1000;
    int          maxlow = 0;
    int          maxhigh = 0;
    logic [63:0] oe_v = '0;
    logic [63:0] out_v = '0;
    logic        prev_ck = 1'b1;

    // Target response for strobe number idx of the current frame.
    function automatic logic plan(input int idx);
        case (cur_op)
            2'b00: begin
                if (idx >= 5 && idx <= 5 + cur_wz) return (idx == 5 + cur_wz);
                if (idx >= 6 + cur_wz && idx < 14 + cur_wz) return cur_rb[idx - 6 - cur_wz];
                return 1'b0;
            end
            2'b10: begin
                if (idx >= 3 && idx <= 10) return cur_rb[idx - 3];
                return 1'b0;
            end
            2'b01: begin
                if (idx >= 13 && idx <= 13 + cur_wz) return (idx == 13 + cur_wz);
                return 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

    // Line monitor and target: records each strobe, answers on falling clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ck && !ck_out) begin
                if (nstb < 64) begin
                    oe_v[nstb]  = dat_oe;
                    out_v[nstb] = dat_out;
                end
                dat_in = plan(nstb);
                if (nstb > 0 && hirun > maxhigh) maxhigh = hirun;
                nstb   = nstb + 1;
                lowrun = 1;
            end else if (!ck_out) begin
                lowrun = lowrun + 1;
            end
            if (!prev_ck && ck_out) begin
                if (lowrun < minlow) minlow = lowrun;
                if (lowrun > maxlow) maxlow = lowrun;
                hirun = 1;
            end else if (ck_out) begin
                hirun = hirun + 1;
            end
            prev_ck = ck_out;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        ncmp++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        nstb = 0; oe_v = '0; out_v = '0;
        minlow = 1000; maxlow = 0; maxhigh = 0;
    endtask

    task automatic wait_done(output logic got_e, output logic [7:0] got_r, output int hr);
        int to = 0;
        while (!done && to < 5000) begin
            @(negedge clk);
            to++;
        end
        got_e = err;
        got_r = rdata;
        hr    = hirun;
        @(negedge clk);
        chk("R10 done lasts one cycle", 64'(done), 64'd0);
    endtask

    task automatic run_frame(input logic [1:0] op, input logic [7:0] d,
                             input int wz, input logic [7:0] rb);
        logic [63:0] eoe = '0;
        logic [63:0] eout = '0;
        int          en = 0;
        int          nw;
        int          hr;
        logic        ok;
        logic        ge;
        logic [7:0]  gr;
        logic [7:0]  erd;
        ok = (op[1] == 1'b1) || (wz < WLIM);
        nw = (wz < WLIM) ? wz + 1 : WLIM;
        // START released, instruction bit 0 then bit 1 (R3)
        en++;
        eoe[en] = 1'b1; eout[en] = op[0]; en++;
        eoe[en] = 1'b1; eout[en] = op[1]; en++;
        if (!op[1]) begin
            // LENGTH 00 for data frames (R4)
            eoe[en] = 1'b1; en++;
            eoe[en] = 1'b1; en++;
        end
        if (op == 2'b11 || op == 2'b01) begin
            for (int i = 0; i < 8; i++) begin
                eoe[en] = 1'b1; eout[en] = d[i]; en++;
            end
        end
        if (op == 2'b10) en += 8;
        if (!op[1]) en += nw;
        if (op == 2'b00 && ok) en += 8;
        if (ok) en++;
        erd = (ok && !op[0]) ? rb : 8'h00;

        cur_op = op; cur_wz = wz; cur_rb = rb;
        clear_mon();
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_reset = 1'b0; req_op = op; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 ready low after accept", 64'(req_ready), 64'd0);
        wait_done(ge, gr, hr);

        if (op[1]) chk("R3 R6 address frame strobe count", 64'(nstb), 64'(en));
        else       chk("R7 R8 data frame strobe count", 64'(nstb), 64'(en));
        chk("R3 R4 R6 R10 line direction per strobe", oe_v, eoe);
        chk("R3 R4 R5 driven bit values", out_v & eoe, eout & eoe);
        chk("R6 R10 returned byte", 64'(gr), 64'(erd));
        chk("R9 error flag", 64'(ge), 64'(!ok));
        chk("R2 shortest low phase", 64'(minlow), 64'(LOW));
        chk("R2 longest low phase", 64'(maxlow), 64'(LOW));
        if (!op[1] && wz > 0)
            chk("R8 pause between polls", 64'(maxhigh >= HIGH + WGAP), 64'd1);
    endtask

    task automatic run_reset();
        logic       ge;
        logic [7:0] gr;
        int         hr;
        clear_mon();
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_reset = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_reset = 1'b0;
        chk("R12 ready low during reset request", 64'(req_ready), 64'd0);
        wait_done(ge, gr, hr);
        chk("R11 single low pulse", 64'(nstb), 64'd1);
        chk("R11 long low width", 64'(maxlow), 64'(RLOW));
        chk("R11 recovery high time", 64'(hr >= RHIGH), 64'd1);
        chk("R11 no error", 64'(ge), 64'd0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 190000) begin
                nfail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset clock enable", 64'(ck_oe), 64'd0);
        chk("R1 reset clock level", 64'(ck_out), 64'd1);
        chk("R1 reset data released", 64'(dat_oe), 64'd0);
        chk("R1 not ready without access", 64'(req_ready), 64'd0);
        chk("R10 no done at reset", 64'(done), 64'd0);

        // Request offered while not ready must start nothing (R12).
        clear_mon();
        req_valid = 1'b1; req_op = 2'b11; req_data = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk("R12 ignored request gives no strobe", 64'(nstb), 64'd0);
        chk("R12 ignored request gives no done", 64'(done), 64'd0);

        access_en = 1'b1;
        @(negedge clk);
        chk("R1 clock enable follows access", 64'(ck_oe), 64'd1);
        chk("R1 clock high when enabled", 64'(ck_out), 64'd1);
        chk("R1 ready once enabled", 64'(req_ready), 64'd1);

        run_reset();
        for (int v = 0; v < 256; v++) run_frame(2'b11, 8'(v), 0, 8'h00);
        for (int v = 0; v < 256; v++) run_frame(2'b10, 8'h00, 0, 8'(v));
        for (int v = 0; v < 64; v++) run_frame(2'b01, 8'(v * 4 + 1), v % 3, 8'h00);
        for (int w = 0; w <= WLIM + 1; w++) begin
            run_frame(2'b01, 8'hC3, w, 8'h00);
            for (int b = 0; b < 8; b++) run_frame(2'b00, 8'h00, w, 8'(37 * b + 5));
        end
        run_reset();
        run_frame(2'b10, 8'h00, 0, 8'h81);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end

endmodule